// File: doc/BRIEF.md
# Dual-Channel Pulse-Width Modulator with Buffered Duty

The block drives two pulse-width outputs from two 8-bit period timers. A free-running phase counter splits the core clock into four phases, and one pass through all four phases is one instruction cycle. Each timer advances once per instruction cycle, or only in instruction cycles where the external count-enable input is sampled high. When a timer reaches its period value, it wraps to zero and a new PWM period begins.

Each channel holds a 10-bit duty. The upper eight bits are compared against the timer. The lower two bits are compared against the phase counter, so the falling edge can land on any core clock within an instruction cycle. Software writes the duty into a buffer. That buffer becomes the active duty at the next wrap of the channel's timer. A read returns the active duty, not the buffered one. Channel 1 always runs from timer 1. Channel 2 runs from timer 1 or timer 2, as a select bit chooses. Each timer also sets a sticky flag at every wrap.

Top module: `dual_pwm`

## Requirements
- R1: With the timer advancing every instruction cycle, a PWM period lasts (P+1)*4 core clocks, where P is the period register of the timer driving the channel (address 0 for timer 1, address 1 for timer 2).
- R2: An output is high from the start of a period for exactly D core clocks. D is the active 10-bit duty, formed from the high byte (address 2 for channel 1, address 4 for channel 2) above bits 7:6 of the low byte (address 3 or 5).
- R3: A duty of zero keeps the output low for the whole period.
- R4: When the duty high byte equals P, the output goes low for the last 4-F core clocks of the period, where F is duty bits 1:0.
- R5: When the duty high byte exceeds P, the output stays high for the whole period.
- R6: A duty write goes only to the buffer. The active duty changes only at a wrap of the channel's timer, so a write in the middle of a period leaves that period unchanged.
- R7: A read of a duty register returns the active duty. The high byte reads as is, and the low byte reads with the fraction in bits 7:6.
- R8: Bit 5 of address 5 selects channel 2's timebase: 0 selects timer 1 and 1 selects timer 2. This bit takes effect at once and reads back at bit 5.
- R9: A timer wrap sets that timer's flag (irq bit 0 for timer 1, bit 1 for timer 2). The flag holds until a write to address 7 with a 1 in that bit, and a wrap in the same cycle wins.
- R10: Bit i of address 6 makes timer i+1 count only in instruction cycles where ext_cnt is high at the last phase. While ext_cnt stays low, that timer does not wrap.
- R11: After reset, all registers, timers and flags read zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| ext_cnt | input | 1 | External count enable |
| irq | output | 2 | Sticky wrap flags, one per timer |
| pwm | output | 2 | PWM outputs, channel 1 in bit 0 |

## Verification
The hardest case to reach is a duty write in the middle of a period that must not disturb that period while a read still shows the old duty. The stimulus first synchronises to a wrap by clearing the flag and polling it. It then writes the new duty two cycles into the period, reads it back a cycle later, and counts high clocks across that period and the next. The same synchronisation drives the equal-high-byte cases for every fraction value. It also covers a timebase switch of channel 2 whose duty loads on timer 1's wrap.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [2:0] {
    A_PER1 = 3'd0,
    A_PER2 = 3'd1,
    A_D1H  = 3'd2,
    A_D1L  = 3'd3,
    A_D2H  = 3'd4,
    A_D2L  = 3'd5,
    A_CTRL = 3'd6,
    A_FLAG = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/pwm_timer.sv
module pwm_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          use_ext,
  input  logic          ext_cnt,
  input  logic          per_we,
  input  logic [TW-1:0] wdata,
  output logic [TW-1:0] cnt,
  output logic [TW-1:0] per,
  output logic          roll
);
  logic          adv;
  logic [TW-1:0] cnt_nx, per_nx;

  assign adv  = step & (use_ext ? ext_cnt : 1'b1);
  assign roll = adv & (cnt == per);

  always_comb begin
    cnt_nx = cnt;
    if (roll)     cnt_nx = '0;
    else if (adv) cnt_nx = cnt + 1'b1;
    per_nx = per_we ? wdata : per;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      per <= '0;
    end else begin
      cnt <= cnt_nx;
      per <= per_nx;
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int TW = 8,
  parameter int FW = 2,
  localparam int DW = TW + FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hi_we,
  input  logic          lo_we,
  input  logic [TW-1:0] wdata,
  input  logic          load,
  input  logic [DW-1:0] pos,
  output logic [DW-1:0] duty_act,
  output logic          pwm
);
  logic [DW-1:0] master, master_nx, slave_nx;

  always_comb begin
    master_nx = master;
    if (hi_we) master_nx[DW-1:FW] = wdata;
    if (lo_we) master_nx[FW-1:0]  = wdata[TW-1 -: FW];
    slave_nx  = load ? master : duty_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master   <= '0;
      duty_act <= '0;
    end else begin
      master   <= master_nx;
      duty_act <= slave_nx;
    end
  end

  assign pwm = (pos < duty_act);
endmodule

// File: rtl/dual_pwm.sv
module dual_pwm #(
  parameter int TW = 8,
  parameter int FW = 2,
  localparam int DW  = TW + FW,
  localparam int SEL = TW - 1 - FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [TW-1:0] wdata,
  output logic [TW-1:0] rdata,
  input  logic          ext_cnt,
  output logic [1:0]    irq,
  output logic [1:0]    pwm
);
  import pwm_pkg::*;

  reg_addr_e adr;
  assign adr = reg_addr_e'(addr);

  logic [FW-1:0]      ph, ph_nx;
  logic               step;
  logic [1:0]         ext_sel, ext_sel_nx;
  logic               sel2, sel2_nx;
  logic [1:0]         flags, flags_nx;
  logic [1:0][TW-1:0] tcnt, tper;
  logic [1:0]         troll;
  logic [1:0][DW-1:0] dc_act;
  logic [1:0]         src;

  assign step = &ph;
  assign src  = {sel2, 1'b0};

  for (genvar i = 0; i < 2; i++) begin : g_tmr
    pwm_timer #(.TW(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .step(step),
      .use_ext(ext_sel[i]), .ext_cnt(ext_cnt),
      .per_we(wr_en && addr == 3'(i)), .wdata(wdata),
      .cnt(tcnt[i]), .per(tper[i]), .roll(troll[i])
    );
  end

  for (genvar i = 0; i < 2; i++) begin : g_ch
    pwm_channel #(.TW(TW), .FW(FW)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .hi_we(wr_en && addr == 3'(2 + 2*i)),
      .lo_we(wr_en && addr == 3'(3 + 2*i)),
      .wdata(wdata), .load(troll[src[i]]),
      .pos({tcnt[src[i]], ph}),
      .duty_act(dc_act[i]), .pwm(pwm[i])
    );
  end

  always_comb begin
    ph_nx      = ph + 1'b1;
    ext_sel_nx = (wr_en && adr == A_CTRL) ? wdata[1:0] : ext_sel;
    sel2_nx    = (wr_en && adr == A_D2L) ? wdata[SEL] : sel2;
    for (int i = 0; i < 2; i++)
      flags_nx[i] = troll[i] | (flags[i] & ~(wr_en && adr == A_FLAG && wdata[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= '0;
      ext_sel <= '0;
      sel2    <= 1'b0;
      flags   <= '0;
    end else begin
      ph      <= ph_nx;
      ext_sel <= ext_sel_nx;
      sel2    <= sel2_nx;
      flags   <= flags_nx;
    end
  end

  always_comb begin
    rdata = '0;
    case (adr)
      A_PER1: rdata = tper[0];
      A_PER2: rdata = tper[1];
      A_D1H:  rdata = dc_act[0][DW-1:FW];
      A_D1L:  rdata[TW-1 -: FW] = dc_act[0][FW-1:0];
      A_D2H:  rdata = dc_act[1][DW-1:FW];
      A_D2L: begin
        rdata[TW-1 -: FW] = dc_act[1][FW-1:0];
        rdata[SEL]        = sel2;
      end
      A_CTRL: rdata[1:0] = ext_sel;
      A_FLAG: rdata[1:0] = flags;
      default: rdata = '0;
    endcase
  end

  assign irq = flags;
endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
  parameter int TW = 8,
  parameter int FW = 2,
  localparam int DW = TW + FW
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [2:0]         addr,
  input logic [TW-1:0]      wdata,
  input logic [1:0]         irq,
  input logic [1:0]         pwm,
  input logic [1:0][TW-1:0] tcnt,
  input logic [1:0]         troll,
  input logic [1:0][DW-1:0] dc_act
);
  a_r1_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    troll[0] |=> (tcnt[0] == '0));
  a_r3_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_act[0] == '0) |-> !pwm[0]);
  a_r5_above_high: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_act[0][DW-1:FW] > tcnt[0]) |-> pwm[0]);
  a_r6_hold_duty: assert property (@(posedge clk) disable iff (!rst_n)
    !troll[0] |=> $stable(dc_act[0]));
  a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    troll[1] |=> irq[1]);
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq[0] && !(wr_en && addr == 3'd7 && wdata[0])) |=> irq[0]);
endmodule

bind dual_pwm pwm_checker #(.TW(TW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .pwm(pwm), .tcnt(tcnt), .troll(troll), .dc_act(dc_act)
);

// File: tb/sim_dual_pwm.sv
`timescale 1ns/1ps
module sim_dual_pwm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       ext_cnt = 1'b0;
  logic [1:0] irq, pwm;

  int checks = 0, errors = 0;
  bit run_cmp = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_pwm u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ext_cnt(ext_cnt), .irq(irq), .pwm(pwm));

  // behavioural reference
  int m_ph, m_t[2], m_per[2], m_mas[2], m_sla[2], m_ext[2], m_flag[2], m_sel;

  always @(posedge clk) begin
    int r[2];
    int en;
    if (!rst_n) begin
      m_ph = 0; m_sel = 0;
      for (int i = 0; i < 2; i++) begin
        m_t[i] = 0; m_per[i] = 0; m_mas[i] = 0; m_sla[i] = 0; m_ext[i] = 0; m_flag[i] = 0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        en = (m_ph == 3) && (m_ext[i] == 0 || ext_cnt);
        r[i] = en && (m_t[i] == m_per[i]);
        if (r[i]) m_t[i] = 0;
        else if (en) m_t[i] = (m_t[i] + 1) % 256;
      end
      if (r[0]) m_sla[0] = m_mas[0];
      if (r[m_sel]) m_sla[1] = m_mas[1];
      for (int i = 0; i < 2; i++)
        m_flag[i] = (r[i] || (m_flag[i] && !(wr_en && addr == 7 && wdata[i]))) ? 1 : 0;
      if (wr_en) begin
        case (addr)
          0: m_per[0] = wdata;
          1: m_per[1] = wdata;
          2: m_mas[0] = (wdata << 2) | (m_mas[0] & 3);
          3: m_mas[0] = (m_mas[0] & ~3) | (wdata >> 6);
          4: m_mas[1] = (wdata << 2) | (m_mas[1] & 3);
          5: begin m_mas[1] = (m_mas[1] & ~3) | (wdata >> 6); m_sel = (wdata >> 5) & 1; end
          6: begin m_ext[0] = wdata[0]; m_ext[1] = wdata[1]; end
          default: ;
        endcase
      end
      m_ph = (m_ph + 1) % 4;
    end
  end

  function automatic int exp_rd(int a);
    case (a)
      0: return m_per[0];
      1: return m_per[1];
      2: return m_sla[0] >> 2;
      3: return (m_sla[0] & 3) << 6;
      4: return m_sla[1] >> 2;
      5: return ((m_sla[1] & 3) << 6) | (m_sel << 5);
      6: return m_ext[0] | (m_ext[1] << 1);
      default: return m_flag[0] | (m_flag[1] << 1);
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    #1;
    if (run_cmp && !done) begin
      for (int i = 0; i < 2; i++) begin
        int src, e;
        src = (i == 1) ? m_sel : 0;
        e = ((m_t[src] * 4 + m_ph) < m_sla[i]) ? 1 : 0;
        check(pwm[i] == e[0], "R2 pwm vs model", pwm[i], e);
        check(irq[i] == m_flag[i][0], "R9 flag vs model", irq[i], m_flag[i]);
      end
      check(rdata == 8'(exp_rd(addr)), "R7 rdata vs model", rdata, exp_rd(addr));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // sync to a wrap of timer fi, then count high clocks of pwm[ch] over one period
  task automatic measure(input int ch, input int fi, input int do_mid, input int mid_val,
                         input int old_rd, input int exp_hi, input int exp_p, input string tag);
    int hi = 0, c = 0;
    wr(7, 3);
    do begin @(negedge clk); #1; end while (!irq[fi]);
    wr_en = 1'b1; addr = 3'd7; wdata = 8'(1 << fi);
    do begin
      hi += pwm[ch];
      c++;
      @(negedge clk);
      wr_en = 1'b0;
      if (do_mid && c == 2) begin wr_en = 1'b1; addr = 3'(2 + 2*ch); wdata = 8'(mid_val); end
      if (do_mid && c == 3) addr = 3'(2 + 2*ch);
      #1;
      if (do_mid && c == 3) check(rdata == 8'(old_rd), "R7 read shows active duty", rdata, old_rd);
    end while (!irq[fi] && c < 3000);
    check(hi == exp_hi, tag, hi, exp_hi);
    check(c == exp_p, "R1 period length", c, exp_p);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(pwm == 2'b00, "R11 outputs low in reset", pwm, 0);
    check(irq == 2'b00, "R11 flags clear in reset", irq, 0);
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #0.5;
      check(rdata == 8'd0, "R11 register zero after reset", rdata, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    run_cmp = 1'b1;

    wr(0, 9);                               // P = 40 clocks
    wr(2, 5); wr(3, 8'h80);                 // D = 22
    measure(0, 0, 0, 0, 0, 22, 40, "R2 high time D=22");
    wr(2, 0); wr(3, 0);
    measure(0, 0, 0, 0, 0, 0, 40, "R3 zero duty");
    for (int f = 0; f < 4; f++) begin
      wr(2, 9); wr(3, f << 6);
      measure(0, 0, 0, 0, 0, 36 + f, 40, "R4 high byte equals period");
    end
    wr(2, 10); wr(3, 0);
    measure(0, 0, 0, 0, 0, 40, 40, "R5 high byte above period");
    wr(2, 3);
    measure(0, 0, 0, 0, 0, 12, 40, "R6 settle D=12");
    measure(0, 0, 1, 7, 3, 12, 40, "R6 mid-period write ignored");
    measure(0, 0, 0, 0, 0, 28, 40, "R6 new duty after wrap");

    wr(1, 4);                               // timer 2: P = 20
    wr(4, 2); wr(5, 8'h60);                 // D = 9, select timer 2
    measure(1, 1, 0, 0, 0, 9, 20, "R8 channel 2 on timer 2");
    wr(5, 8'h40);                           // back to timer 1
    measure(1, 0, 0, 0, 0, 9, 40, "R8 channel 2 on timer 1");

    ext_cnt = 1'b0;
    wr(6, 1);
    repeat (8) @(negedge clk);
    #1 check(irq[0] == 1'b1, "R9 flag held", irq[0], 1);
    wr(7, 2);
    #1 check(irq[0] == 1'b1, "R9 clear of other bit ignored", irq[0], 1);
    wr(7, 1);
    #1 check(irq[0] == 1'b0, "R9 write-one clears", irq[0], 0);
    repeat (200) @(negedge clk);
    #1 check(irq[0] == 1'b0, "R10 stalled timer does not wrap", irq[0], 0);
    ext_cnt = 1'b1;
    measure(0, 0, 0, 0, 0, 28, 40, "R10 enabled counting");
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (k % 3 == 0) ext_cnt = ~ext_cnt;
    end
    wr(6, 0);
    repeat (50) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule